// File: doc/BRIEF.md
# Four-Channel Pulse-Width DAC

This block turns four 8-bit duty codes into four pulse-width modulated pin levels, one per channel, for an external RC filter to smooth into a voltage. All channels share one free-running 256-step counter. A prescaler advances the counter once every `TICK_DIV` system clocks. With a 4.5 MHz clock and the default `TICK_DIV` of 2, the repetition rate is about 8.79 kHz, a period of about 114 µs.

Each channel holds a duty code in two stages. A load command writes the pending register. The active register copies the pending value only when the shared counter wraps from 255 back to 0, so a new code can take up to one full period to appear.

Each output models an N-channel open-drain pin: a 1 on `pin_o` means the transistor is off and the pin floats high. A per-channel mode bit selects between a general-purpose output latch and the PWM waveform. The clock-stop input forces every transistor off.

Top module: `pwm_dac_quad`

## Requirements
- R1: After synchronous reset all four `pin_o` bits are 1 (transistor off). Every channel is in general-purpose mode with its latch bit at 1, and pending and active duty are 0.
- R2: In general-purpose mode (mode bit 0) a channel's `pin_o` bit equals its latch bit, with 1 meaning transistor off. A latch write with `gpo_wr` takes effect on the clock edge that samples it.
- R3: The shared counter advances by one every `TICK_DIV` clocks while `clk_stop` is low. It counts 0 to 255 and wraps, so the PWM period is 256 × `TICK_DIV` clocks.
- R4: In PWM mode (mode bit 1) a channel's `pin_o` bit is 0 while the counter is below the active duty and 1 otherwise. Duty 0 keeps the pin high for the whole period; duty 255 keeps it low for 255 of 256 steps.
- R5: A load (`load_valid`, channel in `load_sel`) changes only that channel's pending value. The previously active duty keeps driving the pin until the next wrap from 255 to 0, when all channels copy pending into active.
- R6: When a load is sampled on the same edge as a wrap, the active duty takes the pending value held before that edge. The newly loaded code becomes active at the following wrap.
- R7: Setting a mode bit to 1 switches that pin to the PWM waveform on the next clock, using the current active duty, without any new load.
- R8: Channels are independent: a load or mode change on one channel leaves the waveform of every other channel unchanged.
- R9: While `clk_stop` is 1 every `pin_o` bit is 1 and the counter and prescaler hold their values. Counting resumes from the held value when `clk_stop` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_stop | input | 1 | Clock-stop mode: forces transistors off and freezes counting |
| load_valid | input | 1 | Load command strobe for a pending duty register |
| load_sel | input | 2 | Channel addressed by the load command |
| load_data | input | 8 | Duty code to load |
| mode_wr | input | 1 | Write strobe for the per-channel mode bits |
| mode_val | input | 4 | Mode bits, 1 = PWM, 0 = general-purpose output |
| gpo_wr | input | 1 | Write strobe for the general-purpose latch |
| gpo_val | input | 4 | Latch bits, 1 = transistor off |
| pin_o | output | 4 | Pin levels, 1 = transistor off (high), 0 = pulled low |

## Verification
The waveform is tried with duty codes 0, 1, 37, 128 and 255 spread across the four channels. Measuring the low time of each channel over a whole period separates the two extreme codes from the compare edge and exposes any crosstalk between channels. Loads placed mid-period and exactly on the wrap edge show whether a design transfers codes early, late or from the wrong stage. Mode flips, latch patterns and a clock-stop interval in the middle of a period separate the output multiplexing from the counter freeze and resume. A cycle-by-cycle comparison against a bench model built from the requirements runs across these windows.

// File: rtl/pwm_dac_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the pulse-width DAC.
// Assumes: nothing beyond IEEE 1800-2017.
package pwm_dac_pkg;

    // Source that drives one output pin.
    typedef enum logic [1:0] {
        SRC_OFF = 2'd0,   // transistor forced off
        SRC_GPO = 2'd1,   // general-purpose latch bit
        SRC_PWM = 2'd2    // comparator waveform
    } pin_src_e;

endpackage

// File: rtl/pwm_dac_timebase.sv
`timescale 1ns/1ps
// Module: pwm_dac_timebase
// Shared prescaler and period counter. The counter steps once every TICK_DIV
// clocks and wraps from all ones to zero; wrap_o marks the step that wraps.
// Assumes: TICK_DIV >= 2; freeze holds both prescaler and counter.
module pwm_dac_timebase #(
    parameter int TICK_DIV = 2,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze,
    output logic [CNT_W-1:0] cnt_o,
    output logic             tick_o,
    output logic             wrap_o
);
    localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;

    // Step strobe and wrap strobe from the current prescaler and counter state.
    always_comb begin
        tick_o = !freeze && (pre_q == PRE_LAST);
        wrap_o = tick_o && (cnt_q == CNT_LAST);
    end

    // Prescaler: counts clocks between counter steps.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (!freeze)
            pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
    end

    // Period counter: advances on each step, wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick_o)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_dac_channel.sv
`timescale 1ns/1ps
// Module: pwm_dac_channel
// One DAC channel: pending and active duty registers plus output selection.
// Pending is written by load_en; active copies pending only on wrap.
// Output polarity models an open-drain pin: 1 = transistor off.
// Assumes: cnt and wrap come from the shared timebase.
module pwm_dac_channel
    import pwm_dac_pkg::*;
#(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [DUTY_W-1:0] load_data,
    input  logic              wrap,
    input  logic [DUTY_W-1:0] cnt,
    input  logic              pwm_mode,
    input  logic              gpo_bit,
    input  logic              halt,
    output logic              pin,
    output logic [DUTY_W-1:0] act_o,
    output logic [DUTY_W-1:0] pend_o
);
    logic [DUTY_W-1:0] pend_q;
    logic [DUTY_W-1:0] act_q;
    pin_src_e          src;

    // Pending stage: holds the latest loaded duty code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else if (load_en)
            pend_q <= load_data;
    end

    // Active stage: takes the pending code at the period boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_q <= '0;
        else if (wrap)
            act_q <= pend_q;
    end

    // Source selection: clock stop overrides mode.
    always_comb begin
        if (halt)
            src = SRC_OFF;
        else if (pwm_mode)
            src = SRC_PWM;
        else
            src = SRC_GPO;
    end

    // Pin level: transistor on (0) while counter is below the active duty.
    always_comb begin
        case (src)
            SRC_PWM: pin = !(cnt < act_q);
            SRC_GPO: pin = gpo_bit;
            default: pin = 1'b1;
        endcase
    end

    assign act_o  = act_q;
    assign pend_o = pend_q;
endmodule

// File: rtl/pwm_dac_quad.sv
`timescale 1ns/1ps
// Module: pwm_dac_quad
// Multi-channel pulse-width DAC with a shared period counter, double-buffered
// duty codes, per-channel mode bits and a general-purpose output latch.
// Assumes: single clock domain, synchronous active-low reset, CH >= 2.
module pwm_dac_quad #(
    parameter int CH       = 4,
    parameter int DUTY_W   = 8,
    parameter int TICK_DIV = 2,
    localparam int SEL_W   = $clog2(CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_stop,
    input  logic              load_valid,
    input  logic [SEL_W-1:0]  load_sel,
    input  logic [DUTY_W-1:0] load_data,
    input  logic              mode_wr,
    input  logic [CH-1:0]     mode_val,
    input  logic              gpo_wr,
    input  logic [CH-1:0]     gpo_val,
    output logic [CH-1:0]     pin_o
);
    logic [DUTY_W-1:0]    cnt_w;
    logic                 tick_w;
    logic                 wrap_w;
    logic [CH-1:0]        mode_q;
    logic [CH-1:0]        gpo_q;
    logic [CH*DUTY_W-1:0] act_flat;
    logic [CH*DUTY_W-1:0] pend_flat;

    // Mode bits: reset to general-purpose output for every channel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (mode_wr)
            mode_q <= mode_val;
    end

    // Output latch: reset to transistor off for every channel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gpo_q <= '1;
        else if (gpo_wr)
            gpo_q <= gpo_val;
    end

    pwm_dac_timebase #(
        .TICK_DIV (TICK_DIV),
        .CNT_W    (DUTY_W)
    ) u_timebase (
        .clk    (clk),
        .rst_n  (rst_n),
        .freeze (clk_stop),
        .cnt_o  (cnt_w),
        .tick_o (tick_w),
        .wrap_o (wrap_w)
    );

    for (genvar c = 0; c < CH; c++) begin : g_ch
        pwm_dac_channel #(
            .DUTY_W (DUTY_W)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_en   (load_valid && (load_sel == SEL_W'(c))),
            .load_data (load_data),
            .wrap      (wrap_w),
            .cnt       (cnt_w),
            .pwm_mode  (mode_q[c]),
            .gpo_bit   (gpo_q[c]),
            .halt      (clk_stop),
            .pin       (pin_o[c]),
            .act_o     (act_flat[c*DUTY_W +: DUTY_W]),
            .pend_o    (pend_flat[c*DUTY_W +: DUTY_W])
        );
    end
endmodule

// File: rtl/pwm_dac_quad_sva.sv
`timescale 1ns/1ps
// Module: pwm_dac_quad_sva
// Property checker for pwm_dac_quad, attached through bind below.
// Assumes: connected to the top-level internal nets of the same names.
module pwm_dac_quad_sva #(
    parameter int CH     = 4,
    parameter int DUTY_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 clk_stop,
    input logic                 mode_wr,
    input logic                 gpo_wr,
    input logic [CH-1:0]        gpo_val,
    input logic [CH-1:0]        mode_q,
    input logic [CH-1:0]        pin_o,
    input logic                 tick_w,
    input logic                 wrap_w,
    input logic [DUTY_W-1:0]    cnt_w,
    input logic [CH*DUTY_W-1:0] act_flat,
    input logic [CH*DUTY_W-1:0] pend_flat
);
    logic was_rst;

    // Remembers that the previous edge was in reset.
    always_ff @(posedge clk) was_rst <= !rst_n;

    // R1: first cycle out of reset shows every transistor off.
    always @(posedge clk) begin
        if (rst_n && was_rst)
            p_reset_idle_r1: assert (&pin_o);
    end

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_w |=> cnt_w == DUTY_W'($past(cnt_w) + 1'b1));

    p_hold_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_w |=> $stable(cnt_w));

    p_active_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_w |=> $stable(act_flat));

    p_transfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_w |=> act_flat == $past(pend_flat));

    p_stop_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop |-> &pin_o);

    for (genvar c = 0; c < CH; c++) begin : g_chk
        p_gpo_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (gpo_wr && !mode_wr && !mode_q[c]) |=>
                (clk_stop || pin_o[c] == $past(gpo_val[c])));

        p_zero_duty_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[c] && !clk_stop && act_flat[c*DUTY_W +: DUTY_W] == '0)
                |-> pin_o[c]);
    end
endmodule

bind pwm_dac_quad pwm_dac_quad_sva #(
    .CH     (CH),
    .DUTY_W (DUTY_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_stop  (clk_stop),
    .mode_wr   (mode_wr),
    .gpo_wr    (gpo_wr),
    .gpo_val   (gpo_val),
    .mode_q    (mode_q),
    .pin_o     (pin_o),
    .tick_w    (tick_w),
    .wrap_w    (wrap_w),
    .cnt_w     (cnt_w),
    .act_flat  (act_flat),
    .pend_flat (pend_flat)
);

// File: tb/pwm_dac_quad_bench.sv
`timescale 1ns/1ps
// Directed bench for pwm_dac_quad; each task drives one scenario and checks it.
module pwm_dac_quad_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TICK       = 2;
    localparam int STEPS      = 256;
    localparam int PERIOD     = STEPS * TICK;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_stop = 1'b0;
    logic       load_valid = 1'b0;
    logic [1:0] load_sel = '0;
    logic [7:0] load_data = '0;
    logic       mode_wr = 1'b0;
    logic [3:0] mode_val = '0;
    logic       gpo_wr = 1'b0;
    logic [3:0] gpo_val = '0;
    logic [3:0] pin_o;

    int checks = 0;
    int errors = 0;

    // Reference state derived from the requirements.
    int         edges;
    logic [7:0] m_pend [4];
    logic [7:0] m_act  [4];
    logic [3:0] m_mode;
    logic [3:0] m_gpo;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_dac_quad #(.CH(4), .DUTY_W(8), .TICK_DIV(TICK)) u_pwm_dac_quad (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_stop   (clk_stop),
        .load_valid (load_valid),
        .load_sel   (load_sel),
        .load_data  (load_data),
        .mode_wr    (mode_wr),
        .mode_val   (mode_val),
        .gpo_wr     (gpo_wr),
        .gpo_val    (gpo_val),
        .pin_o      (pin_o)
    );

    // Reference model update at each clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            edges  <= 0;
            m_mode <= '0;
            m_gpo  <= '1;
            for (int c = 0; c < 4; c++) begin
                m_pend[c] <= '0;
                m_act[c]  <= '0;
            end
        end else begin
            if (!clk_stop) begin
                edges <= edges + 1;
                if ((edges + 1) % PERIOD == 0)
                    for (int c = 0; c < 4; c++) m_act[c] <= m_pend[c];
            end
            if (load_valid) m_pend[load_sel] <= load_data;
            if (mode_wr)    m_mode <= mode_val;
            if (gpo_wr)     m_gpo  <= gpo_val;
        end
    end

    function automatic logic [3:0] exp_pins();
        logic [3:0] e;
        int step;
        step = (edges / TICK) % STEPS;
        for (int c = 0; c < 4; c++) begin
            if (clk_stop)       e[c] = 1'b1;
            else if (m_mode[c]) e[c] = !(step < int'(m_act[c]));
            else                e[c] = m_gpo[c];
        end
        return e;
    endfunction

    task automatic check_val(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Advance to the negedge where the bench edge count sits at phase k.
    task automatic sync_to(input int k);
        @(negedge clk);
        while (edges % PERIOD != k) @(negedge clk);
    endtask

    task automatic do_load(input int ch, input int d);
        load_valid = 1'b1; load_sel = 2'(ch); load_data = 8'(d);
        @(negedge clk);
        load_valid = 1'b0;
    endtask

    task automatic do_mode(input logic [3:0] v);
        mode_wr = 1'b1; mode_val = v;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic do_gpo(input logic [3:0] v);
        gpo_wr = 1'b1; gpo_val = v;
        @(negedge clk);
        gpo_wr = 1'b0;
    endtask

    // One check: pins match the reference model on every cycle of a window.
    task automatic compare_window(input string req, input int n);
        int bad = 0;
        logic [3:0] fa = '0, fe = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pin_o !== exp_pins()) begin
                if (bad == 0) begin fa = pin_o; fe = exp_pins(); end
                bad++;
            end
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s: window mismatch actual %b expected %b", req, fa, fe);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick_n(4);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R1 pins after reset", int'(pin_o), 4'hF);
        compare_window("R1 idle", 20);
    endtask

    task automatic t_gpo();
        do_gpo(4'b0110);
        check_val("R2 latch pattern 0110", int'(pin_o), 4'b0110);
        do_gpo(4'b1001);
        check_val("R2 latch pattern 1001", int'(pin_o), 4'b1001);
        do_gpo(4'b1111);
        check_val("R2 latch all off", int'(pin_o), 4'hF);
    endtask

    task automatic t_period();
        int t0, t1, lw;
        do_load(0, 1);
        sync_to(2);
        do_mode(4'b0001);
        while (pin_o[0] !== 1'b0) @(negedge clk);
        t0 = edges;
        lw = 0;
        while (pin_o[0] === 1'b0) begin lw++; @(negedge clk); end
        while (pin_o[0] !== 1'b0) @(negedge clk);
        t1 = edges;
        check_val("R3 period in clocks", t1 - t0, PERIOD);
        check_val("R3 one step low width", lw, TICK);
    endtask

    task automatic t_duties();
        int lows [4];
        do_load(0, 0);
        do_load(1, 128);
        do_load(2, 255);
        do_load(3, 37);
        do_mode(4'b1111);
        sync_to(0);
        foreach (lows[c]) lows[c] = 0;
        for (int i = 0; i < PERIOD; i++) begin
            for (int c = 0; c < 4; c++) if (pin_o[c] === 1'b0) lows[c]++;
            @(negedge clk);
        end
        check_val("R4 duty 0 low time", lows[0], 0);
        check_val("R4 duty 128 low time", lows[1], 128 * TICK);
        check_val("R4 duty 255 low time", lows[2], 255 * TICK);
        check_val("R8 duty 37 low time", lows[3], 37 * TICK);
        compare_window("R4 R8 model", PERIOD);
    endtask

    task automatic t_double_buffer();
        sync_to(100);
        do_load(1, 10);
        check_val("R5 old duty still drives", int'(pin_o[1]), 0);
        check_val("R8 ch3 unaffected", int'(pin_o[3]), 1);
        sync_to(40);
        check_val("R5 new duty after wrap", int'(pin_o[1]), 1);
        compare_window("R5 model", PERIOD);
    endtask

    task automatic t_wrap_coincide();
        sync_to(PERIOD - 1);
        do_load(3, 200);
        sync_to(150);
        check_val("R6 load on wrap deferred", int'(pin_o[3]), 1);
        sync_to(150);
        check_val("R6 load active next period", int'(pin_o[3]), 0);
    endtask

    task automatic t_mode_switch();
        do_gpo(4'b1111);
        do_mode(4'b1011);
        check_val("R7 pin returns to latch", int'(pin_o[2]), 1);
        sync_to(20);
        do_mode(4'b1111);
        check_val("R7 PWM immediately", int'(pin_o[2]), 0);
        compare_window("R7 model", 64);
    endtask

    task automatic t_stop();
        sync_to(60);
        clk_stop = 1'b1;
        @(negedge clk);
        check_val("R9 all off in stop", int'(pin_o), 4'hF);
        compare_window("R9 stop window", 300);
        clk_stop = 1'b0;
        compare_window("R9 resume", PERIOD + 40);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        t_reset();
        t_gpo();
        t_period();
        t_duties();
        t_double_buffer();
        t_wrap_coincide();
        t_mode_switch();
        t_stop();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule